// File: doc/BRIEF.md
# Serial Line Format Decoder and Bit-Rate Tick Generator

This block holds the framing and bit-rate settings of one serial port. Software writes a line control word, an integer divisor and a 3-bit fractional adjust through a small write-only register port. The block decodes these into the frame parameters that a transmitter and a receiver need: data width, stop bit count, parity enable, parity sense and total frame length. It also produces a one-cycle bit tick from the reference clock.

The tick repeats every 16 × divisor + fraction + 16 reference cycles. A divisor of zero halts the tick. While the divisor is zero, the decoded frame parameters keep the values they last held. A period change made while the generator runs takes effect at the next terminal count, so the current bit is never cut short.

Register addresses: 0 selects the line control word, 1 the divisor and 2 the fractional adjust. Address 3 is reserved.

Top module: `uart_fmt_baud`

## Requirements
- R1: The data bit count equals line control bits [1:0] plus 5, which gives 5 to 8 bits.
- R2: Line control bit 2 set gives 2 stop bits. Bit 2 clear gives 1 stop bit.
- R3: Line control bit 5 enables parity. Parity sense is even when bit 5 and bit 3 are both set, and odd otherwise. The parity sense output is 0 whenever parity is disabled.
- R4: The frame length equals 1 + data bits + parity enable (0 or 1) + stop bits.
- R5: While running, tick_o is high for exactly one cycle in every period. The period is 16 × divisor + fraction + 16 reference cycles, with divisor = wr_data_i[15:0] at address 1 and fraction = wr_data_i[2:0] at address 2.
- R6: Writing a zero divisor stops the ticks from the next cycle and clears the count. While the divisor is zero, line control writes leave every frame output unchanged.
- R7: A write to address 0, 1 or 2 re-evaluates the frame outputs on the next cycle from the stored line control word, provided the divisor after the write is nonzero. A write to address 3 changes nothing.
- R8: A divisor or fraction write made while running takes effect at the next terminal count. This includes a write that lands in the same cycle as a tick.
- R9: When a nonzero divisor is written while halted, the first tick falls P cycles after the write edge, where P is the new period. The count restarts from zero.
- R10: After reset the outputs show 5 data bits, 1 stop bit, no parity and a frame length of 7, and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 line control, 1 divisor, 2 fraction, 3 reserved |
| wr_data_i | input | 16 | Write data |
| data_bits_o | output | 4 | Data bits per frame (5 to 8) |
| stop_bits_o | output | 2 | Stop bits per frame (1 or 2) |
| parity_en_o | output | 1 | Parity enabled |
| parity_even_o | output | 1 | Even parity when high |
| frame_len_o | output | 4 | Total bits per frame |
| tick_o | output | 1 | One-cycle bit period pulse |

## Verification
Two activities can fall in the same cycle: a register write that changes the period, and the terminal count that reloads the counter. The bench waits until it sees tick_o high, then drives a divisor or fraction write at once, so that the write edge is also the reload edge. A behavioural model spaces the following ticks by the newly written period, and every cycle the model's tick and frame values are compared with the ports. The bench also writes the line control word while the divisor is zero and checks that the frame outputs stay frozen until a nonzero divisor arrives.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
  localparam int LINE_W    = 8;
  localparam int LC_STOP   = 2;
  localparam int LC_EVEN   = 3;
  localparam int LC_PAR    = 5;
  localparam int MIN_DATA  = 5;

  typedef enum logic [1:0] {
    ADDR_LINE = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_FRAC = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] data_bits;
    logic [1:0] stop_bits;
    logic       par_en;
    logic       par_even;
    logic [3:0] frame_len;
  } line_fmt_t;

  localparam line_fmt_t FMT_RESET = '{data_bits: 4'd5, stop_bits: 2'd1,
                                      par_en: 1'b0, par_even: 1'b0,
                                      frame_len: 4'd7};
endpackage

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
  import uart_fmt_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  output line_fmt_t         fmt_o
);
  always_comb begin
    fmt_o.data_bits = 4'(line_i[1:0]) + 4'(MIN_DATA);
    fmt_o.stop_bits = line_i[LC_STOP] ? 2'd2 : 2'd1;
    fmt_o.par_en    = line_i[LC_PAR];
    fmt_o.par_even  = line_i[LC_PAR] & line_i[LC_EVEN];
    fmt_o.frame_len = 4'd1 + fmt_o.data_bits + 4'(fmt_o.par_en) + 4'(fmt_o.stop_bits);
  end
endmodule

// File: rtl/uart_fmt_regs.sv
module uart_fmt_regs
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  div_n_o,
  output logic [FRAC_W-1:0] frac_n_o,
  output line_fmt_t         fmt_o
);
  logic [LINE_W-1:0] line_q, line_n;
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  line_fmt_t         fmt_q, fmt_dec;

  // next-state register values, visible to the tick generator on the write edge
  always_comb begin
    line_n   = line_q;
    div_n_o  = div_q;
    frac_n_o = frac_q;
    if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        ADDR_LINE: line_n   = wr_data_i[LINE_W-1:0];
        ADDR_DIV:  div_n_o  = wr_data_i[DIV_W-1:0];
        ADDR_FRAC: frac_n_o = wr_data_i[FRAC_W-1:0];
        default:   ;
      endcase
    end
  end

  uart_fmt_decode u_dec (
    .line_i (line_n),
    .fmt_o  (fmt_dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      div_q  <= '0;
      frac_q <= '0;
      fmt_q  <= FMT_RESET;
    end else begin
      line_q <= line_n;
      div_q  <= div_n_o;
      frac_q <= frac_n_o;
      if (wr_en_i && div_n_o != '0) fmt_q <= fmt_dec;
    end
  end

  assign fmt_o = fmt_q;

  a_r6_fmt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_n_o == '0) |=> $stable(fmt_q));
  a_r1_data_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q.data_bits >= 4'd5 && fmt_q.data_bits <= 4'd8));
  a_r7_rsvd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> $stable(fmt_q));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  localparam int PER_W = DIV_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  logic [PER_W-1:0] per_q, per_new, cnt_q;
  logic             run, term;

  assign per_new = {div_i, 4'b0000} + PER_W'(frac_i) + PER_W'(16);
  assign run     = (per_q != '0);
  assign term    = run && (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (div_i == '0) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (!run || term) begin
      per_q <= per_new;  // start or reload only at terminal count
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign tick_o = term;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r6_halt_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |=> !tick_o);
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_q < per_q));
  a_r8_period_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick_o && div_i != '0) |=> $stable(per_q));
endmodule

// File: rtl/uart_fmt_baud.sv
module uart_fmt_baud
  import uart_fmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [3:0]        data_bits_o,
  output logic [1:0]        stop_bits_o,
  output logic              parity_en_o,
  output logic              parity_even_o,
  output logic [3:0]        frame_len_o,
  output logic              tick_o
);
  logic [DIV_W-1:0]  div_n;
  logic [FRAC_W-1:0] frac_n;
  line_fmt_t         fmt;

  uart_fmt_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .div_n_o   (div_n),
    .frac_n_o  (frac_n),
    .fmt_o     (fmt)
  );

  uart_baud_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_n),
    .frac_i (frac_n),
    .tick_o (tick_o)
  );

  assign data_bits_o   = fmt.data_bits;
  assign stop_bits_o   = fmt.stop_bits;
  assign parity_en_o   = fmt.par_en;
  assign parity_even_o = fmt.par_even;
  assign frame_len_o   = fmt.frame_len;

  a_r4_frame_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_len_o == 4'd1 + data_bits_o + 4'(parity_en_o) + 4'(stop_bits_o));
  a_r3_even_needs_par: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_even_o |-> parity_en_o);
endmodule

// File: tb/uart_fmt_baud_bench.sv
module uart_fmt_baud_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  data_bits, frame_len;
  logic [1:0]  stop_bits;
  logic        par_en, par_even, tick;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  uart_fmt_baud u_uart_fmt_baud (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .data_bits_o(data_bits), .stop_bits_o(stop_bits),
    .parity_en_o(par_en), .parity_even_o(par_even), .frame_len_o(frame_len),
    .tick_o(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_line, m_div, m_frac;
  int e_data = 5, e_stop = 1, e_pe = 0, e_pev = 0, e_frame = 7;
  int m_left = 0;
  bit m_run = 0;

  function automatic bit exp_tick();
    return m_run && (m_left == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_div = 0; m_frac = 0; m_run = 0; m_left = 0;
      e_data = 5; e_stop = 1; e_pe = 0; e_pev = 0; e_frame = 7;
    end else begin
      bit fire;
      fire = exp_tick();
      if (wr_en) begin
        if (wr_addr == 2'd0) m_line = int'(wr_data[7:0]);
        if (wr_addr == 2'd1) m_div  = int'(wr_data);
        if (wr_addr == 2'd2) m_frac = int'(wr_data[2:0]);
        if (m_div != 0) begin
          e_data  = (m_line % 4) + 5;
          e_stop  = ((m_line / 4) % 2 == 1) ? 2 : 1;
          e_pe    = (m_line / 32) % 2;
          e_pev   = e_pe * ((m_line / 8) % 2);
          e_frame = 1 + e_data + e_pe + e_stop;
        end
      end
      if (m_div == 0) begin
        m_run = 0;
      end else if (!m_run || fire) begin
        m_run = 1;
        m_left = 16 * m_div + m_frac + 16 - 1;
      end else begin
        m_left--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk(data_bits == 4'(e_data), "R1 data bits", int'(data_bits), e_data);
      chk(stop_bits == 2'(e_stop), "R2 stop bits", int'(stop_bits), e_stop);
      chk(par_en == e_pe[0] && par_even == e_pev[0], "R3 parity",
          int'({par_en, par_even}), e_pe * 2 + e_pev);
      chk(frame_len == 4'(e_frame), "R4 frame length", int'(frame_len), e_frame);
      chk(tick == exp_tick(), "R5 R8 tick", int'(tick), int'(exp_tick()));
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a write on the very edge that ends the current period
  task automatic wr_on_tick(input int addr, input int data);
    do @(negedge clk); while (!tick);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_gap(input int exp, input string tag);
    int g = 0;
    do @(negedge clk); while (!tick);
    do begin @(negedge clk); g++; end while (!tick && g < 2000);
    chk(g == exp, tag, g, exp);
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    idle(2);
    // R10 reset state
    chk(data_bits == 4'd5 && stop_bits == 2'd1 && !par_en && frame_len == 4'd7,
        "R10 reset format", int'(frame_len), 7);
    chk(tick == 1'b0, "R10 no tick after reset", int'(tick), 0);
    // R6 line writes with zero divisor are frozen
    wr(0, 8'h2F);
    chk(frame_len == 4'd7 && data_bits == 4'd5, "R6 frozen format", int'(frame_len), 7);
    // R7 R9 nonzero divisor applies stored line word, starts ticks
    wr(1, 1);
    chk(data_bits == 4'd8 && stop_bits == 2'd2 && par_en && par_even,
        "R7 format applied", int'(data_bits), 8);
    chk(frame_len == 4'd12, "R4 frame 12", int'(frame_len), 12);
    tick_gap(32, "R5 period 32");
    // R8 fraction change mid-period
    idle(7);
    wr(2, 3);
    tick_gap(35, "R8 period 35");
    // R3 odd parity, R1 six bits
    wr(0, 8'h21);
    chk(par_en && !par_even && data_bits == 4'd6, "R3 odd parity", int'(par_even), 0);
    chk(frame_len == 4'd9, "R4 frame 9", int'(frame_len), 9);
    // R3 even bit without parity enable
    wr(0, 8'h0E);
    chk(!par_en && !par_even && stop_bits == 2'd2 && data_bits == 4'd7,
        "R3 parity off", int'(par_even), 0);
    // R7 reserved address
    wr(3, 16'hFFFF);
    chk(frame_len == 4'd10, "R7 reserved ignored", int'(frame_len), 10);
    tick_gap(35, "R7 period unchanged");
    // R6 halt
    wr(1, 0);
    wr(0, 8'h03);
    idle(80);
    chk(data_bits == 4'd7, "R6 format held when halted", int'(data_bits), 7);
    // R9 restart with new period
    wr(2, 7);
    wr(1, 2);
    chk(data_bits == 4'd8 && frame_len == 4'd10, "R7 re-evaluated", int'(frame_len), 10);
    tick_gap(55, "R9 period 55");
    // R8 write coinciding with a tick
    wr_on_tick(1, 3);
    idle(1);
    tick_gap(71, "R8 same-cycle reload 71");
    wr_on_tick(2, 0);
    idle(120);
    idle(200);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule